// File: doc/BRIEF.md
# Passive serial FPGA configuration sequencer

This block is a hardware master that loads a configuration bitstream into a target FPGA whose configuration port listens passively on SPI. A single start pulse runs the whole sequence. The block takes chip select low, pulses the active-low configuration reset of the target, and waits a setup interval. It then shifts the bitstream out MSB first in SPI mode 3, and after the last byte it clocks a fixed run of all-zero bytes with chip select still held. After that it releases chip select, optionally watches the target's done pin under a timeout, and waits a user-mode settling interval before it reports completion.

Bitstream bytes arrive on a valid/ready byte stream with a last flag. The stream is stalled while a byte is on the wire. If the source runs dry in mid-stream, the block parks the serial clock high and keeps chip select asserted until more data arrives. Every interval is a parameter counted in system clock cycles. The defaults assume a 100 MHz clock: a 1 µs reset pulse, a 35 µs setup wait, a 30 µs user-mode wait and a 1 ms done timeout. A request flagged as partial reconfiguration is refused with an error.

Top module: `spi_cfg_seq`

## Requirements
- R1: SCLK idles high and is high whenever cs_n is high. MOSI changes only together with a falling SCLK edge and is stable while SCLK is high, so the target samples on the rising edge. Each byte goes out MSB first, with each SCLK level held CLK_DIV cycles.
- R2: cs_n goes low exactly one cycle before cfg_rst_n goes low. It stays low until the last trailing idle bit has been clocked.
- R3: cfg_rst_n is low for exactly RST_CYCLES clock cycles per sequence and is high at every other time.
- R4: The first falling SCLK edge comes at least SETUP_CYCLES cycles after cfg_rst_n returns high.
- R5: After the byte flagged last, exactly IDLE_BYTES*8 zero bits are clocked out. cs_n rises only after the last of them, and no further SCLK pulse follows.
- R6: s_ready is low while a byte is being shifted. When s_valid is low in mid-stream, SCLK stays high, cs_n stays low and s_ready stays high.
- R7: With the done check enabled and cdone staying low, the sequence ends exactly TIMEOUT_CYCLES cycles after cs_n rises, with timeout and error high and done low.
- R8: With the done check enabled, done rises no sooner than USER_CYCLES and no later than USER_CYCLES+4 cycles after cdone goes high, with error and timeout low.
- R9: With done_chk_en low at start, cdone is ignored: done rises exactly USER_CYCLES cycles after cs_n rises.
- R10: A start with partial_req high sets error, leaves busy low, and toggles neither cs_n nor cfg_rst_n. A later full start clears error.
- R11: operating is high when cdone is high and no sequence is running, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a sequence when idle |
| partial_req | input | 1 | Qualifies start as a partial reconfiguration request (refused) |
| done_chk_en | input | 1 | Sampled at start: 1 polls cdone under the timeout |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | s_data holds a byte |
| s_last | input | 1 | Current byte is the final bitstream byte |
| s_ready | output | 1 | Block accepts the byte this cycle |
| sclk | output | 1 | Serial clock to the target, idle high |
| mosi | output | 1 | Serial data to the target |
| cs_n | output | 1 | Active-low chip select to the target |
| cfg_rst_n | output | 1 | Active-low configuration reset to the target |
| cdone | input | 1 | Configuration-done pin of the target (asynchronous) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Last sequence completed normally |
| error | output | 1 | Last request failed (refused or timed out) |
| timeout | output | 1 | Last sequence timed out waiting for cdone |
| operating | output | 1 | Target reports done and the block is idle |

## Verification
The hardest situation to reach is a source underflow that falls exactly between two bytes of the stream. There the block must keep chip select low and the clock parked high, and it must neither duplicate nor drop a bit when data resumes. The stimulus withholds s_valid for a stretch longer than one byte time after the first byte of a load. At the end of the gap it checks the pins, then compares every bit sampled on a rising SCLK edge against a queue of expected bits that includes the 104 trailing zeros. The timeout exit is reached by holding cdone low through a whole poll window that the bench shortens with a parameter.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LEAD   = 3'd1,
    ST_RST    = 3'd2,
    ST_SETUP  = 3'd3,
    ST_STREAM = 3'd4,
    ST_TRAIL  = 3'd5,
    ST_POLL   = 3'd6,
    ST_USER   = 3'd7
  } seq_state_t;

  // Largest of four interval lengths, sizes the shared interval timer.
  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int unsigned cnt_width(input int unsigned v);
    int unsigned w;
    w = $clog2(v + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // System clock cycles one byte occupies on the wire.
  function automatic int unsigned byte_cycles(input int unsigned half_period);
    return 2 * half_period * BYTE_W;
  endfunction

endpackage

// File: rtl/spi_cfg_timer.sv
module spi_cfg_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter
  import spi_cfg_pkg::*;
#(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              busy,
  output logic              sclk,
  output logic              mosi
);

  localparam int unsigned DW = cnt_width(CLK_DIV);
  localparam int unsigned BW = cnt_width(BYTE_W - 1);
  localparam logic [DW-1:0] DIV_RELOAD = DW'(CLK_DIV - 1);
  localparam logic [BW-1:0] LAST_BIT   = BW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [DW-1:0]     div_q;
  logic [BW-1:0]     bit_q;
  logic              busy_q;
  logic              sclk_q;
  logic              mosi_q;

  // Mode 3: every bit starts with a falling edge that also presents the
  // new data; the rising edge half a period later is where it is sampled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      sclk_q <= 1'b1;
      mosi_q <= 1'b0;
    end else if (load && !busy_q) begin
      busy_q <= 1'b1;
      sh_q   <= din;
      sclk_q <= 1'b0;
      mosi_q <= din[BYTE_W-1];
      bit_q  <= '0;
      div_q  <= DIV_RELOAD;
    end else if (busy_q) begin
      if (div_q != '0) begin
        div_q <= div_q - 1'b1;
      end else if (!sclk_q) begin
        sclk_q <= 1'b1;
        div_q  <= DIV_RELOAD;
      end else if (bit_q == LAST_BIT) begin
        busy_q <= 1'b0;
      end else begin
        bit_q  <= bit_q + 1'b1;
        sclk_q <= 1'b0;
        mosi_q <= sh_q[BYTE_W-2];
        sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
        div_q  <= DIV_RELOAD;
      end
    end
  end

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign mosi = mosi_q;

endmodule

// File: rtl/spi_cfg_seq.sv
module spi_cfg_seq
  import spi_cfg_pkg::*;
#(
  parameter int unsigned CLK_DIV        = 2,
  parameter int unsigned RST_CYCLES     = 100,
  parameter int unsigned SETUP_CYCLES   = 3500,
  parameter int unsigned USER_CYCLES    = 3000,
  parameter int unsigned TIMEOUT_CYCLES = 100000,
  parameter int unsigned IDLE_BYTES     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              partial_req,
  input  logic              done_chk_en,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              cfg_rst_n,
  input  logic              cdone,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              timeout,
  output logic              operating
);

  localparam int unsigned TW  = cnt_width(max4(RST_CYCLES, SETUP_CYCLES,
                                               USER_CYCLES, TIMEOUT_CYCLES));
  localparam int unsigned IBW = cnt_width(IDLE_BYTES);
  localparam logic [TW-1:0]  RST_LD   = TW'(RST_CYCLES - 1);
  localparam logic [TW-1:0]  SETUP_LD = TW'(SETUP_CYCLES - 1);
  localparam logic [TW-1:0]  USER_LD  = TW'(USER_CYCLES - 1);
  localparam logic [TW-1:0]  TMO_LD   = TW'(TIMEOUT_CYCLES - 1);
  localparam logic [IBW-1:0] IDLE_LD  = IBW'(IDLE_BYTES);

  seq_state_t state_q, state_n;

  logic              last_seen_q;
  logic              use_done_q;
  logic [IBW-1:0]    trail_left_q;
  logic              done_q, err_q, tmo_q;
  logic [1:0]        cd_sync_q;
  logic              cdone_s;

  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_zero;
  logic              sh_load;
  logic [BYTE_W-1:0] sh_byte;
  logic              sh_busy;

  // Named internal events
  logic seq_launch;
  logic seq_reject;
  logic byte_take;
  logic poll_expire;
  logic user_finish;
  logic trail_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cd_sync_q <= 2'b00;
    else        cd_sync_q <= {cd_sync_q[0], cdone};
  end
  assign cdone_s = cd_sync_q[1];

  assign s_ready     = (state_q == ST_STREAM) && !sh_busy && !last_seen_q;
  assign byte_take   = s_valid && s_ready;
  assign seq_launch  = (state_q == ST_IDLE) && start && !partial_req;
  assign seq_reject  = (state_q == ST_IDLE) && start && partial_req;
  assign poll_expire = (state_q == ST_POLL) && !cdone_s && tmr_zero;
  assign user_finish = (state_q == ST_USER) && tmr_zero;
  assign trail_entry = (state_q == ST_STREAM) && !byte_take && last_seen_q && !sh_busy;

  always_comb begin
    state_n  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_byte  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (seq_launch) state_n = ST_LEAD;
      end
      ST_LEAD: begin
        state_n  = ST_RST;
        tmr_load = 1'b1;
        tmr_val  = RST_LD;
      end
      ST_RST: begin
        if (tmr_zero) begin
          state_n  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = SETUP_LD;
        end
      end
      ST_SETUP: begin
        if (tmr_zero) state_n = ST_STREAM;
      end
      ST_STREAM: begin
        if (byte_take) begin
          sh_load = 1'b1;
          sh_byte = s_data;
        end else if (trail_entry) begin
          state_n = ST_TRAIL;
        end
      end
      ST_TRAIL: begin
        if (!sh_busy) begin
          if (trail_left_q != '0) begin
            sh_load = 1'b1;
          end else if (use_done_q) begin
            state_n  = ST_POLL;
            tmr_load = 1'b1;
            tmr_val  = TMO_LD;
          end else begin
            state_n  = ST_USER;
            tmr_load = 1'b1;
            tmr_val  = USER_LD;
          end
        end
      end
      ST_POLL: begin
        if (cdone_s) begin
          state_n  = ST_USER;
          tmr_load = 1'b1;
          tmr_val  = USER_LD;
        end else if (tmr_zero) begin
          state_n = ST_IDLE;
        end
      end
      ST_USER: begin
        if (tmr_zero) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      last_seen_q  <= 1'b0;
      use_done_q   <= 1'b0;
      trail_left_q <= '0;
      done_q       <= 1'b0;
      err_q        <= 1'b0;
      tmo_q        <= 1'b0;
    end else begin
      state_q <= state_n;
      if (seq_reject) begin
        err_q  <= 1'b1;
        done_q <= 1'b0;
        tmo_q  <= 1'b0;
      end
      if (seq_launch) begin
        err_q       <= 1'b0;
        done_q      <= 1'b0;
        tmo_q       <= 1'b0;
        use_done_q  <= done_chk_en;
        last_seen_q <= 1'b0;
      end
      if (byte_take && s_last) last_seen_q <= 1'b1;
      if (trail_entry) trail_left_q <= IDLE_LD;
      if ((state_q == ST_TRAIL) && sh_load) trail_left_q <= trail_left_q - 1'b1;
      if (poll_expire) begin
        tmo_q <= 1'b1;
        err_q <= 1'b1;
      end
      if (user_finish) done_q <= 1'b1;
    end
  end

  spi_cfg_timer #(.W(TW)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  spi_cfg_shifter #(.CLK_DIV(CLK_DIV)) shf_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sh_load),
    .din   (sh_byte),
    .busy  (sh_busy),
    .sclk  (sclk),
    .mosi  (mosi)
  );

  assign cs_n      = !((state_q == ST_LEAD) || (state_q == ST_RST) || (state_q == ST_SETUP) ||
                       (state_q == ST_STREAM) || (state_q == ST_TRAIL));
  assign cfg_rst_n = (state_q != ST_RST);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign error     = err_q;
  assign timeout   = tmo_q;
  assign operating = cdone_s && (state_q == ST_IDLE);

endmodule

// File: rtl/spi_cfg_seq_chk.sv
module spi_cfg_seq_chk #(
  parameter int unsigned RST_CYCLES   = 100,
  parameter int unsigned SETUP_CYCLES = 3500
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic partial_req,
  input logic busy,
  input logic cs_n,
  input logic cfg_rst_n,
  input logic sclk,
  input logic mosi,
  input logic s_ready,
  input logic sh_busy,
  input logic done,
  input logic error,
  input logic timeout,
  input logic operating
);

  int unsigned low_len;
  int unsigned gap_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len <= 0;
      gap_len <= 0;
    end else begin
      low_len <= cfg_rst_n ? 0 : low_len + 1;
      if (!cfg_rst_n)              gap_len <= 0;
      else if (gap_len < 32'h7fff_ffff) gap_len <= gap_len + 1;
    end
  end

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R1
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk) && !$past(cs_n)) |-> $stable(mosi));

  // R2
  cs_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rst_n |-> !cs_n);

  // R2
  cs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> cfg_rst_n);

  // R3
  rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rst_n) |-> (low_len == RST_CYCLES));

  // R4
  setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (gap_len >= SETUP_CYCLES));

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !s_ready);

  // R7
  tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (error && !done));

  // R10
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && partial_req && !busy) |=> (cs_n && cfg_rst_n && error && !busy));

  // R11
  oper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    operating |-> !busy);

endmodule

bind spi_cfg_seq spi_cfg_seq_chk #(
  .RST_CYCLES   (RST_CYCLES),
  .SETUP_CYCLES (SETUP_CYCLES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .partial_req (partial_req),
  .busy        (busy),
  .cs_n        (cs_n),
  .cfg_rst_n   (cfg_rst_n),
  .sclk        (sclk),
  .mosi        (mosi),
  .s_ready     (s_ready),
  .sh_busy     (sh_busy),
  .done        (done),
  .error       (error),
  .timeout     (timeout),
  .operating   (operating)
);

// File: tb/spi_cfg_seq_tb_top.sv
module spi_cfg_seq_tb_top;

  localparam int DIV   = 2;
  localparam int RSTC  = 100;
  localparam int SETUP = 3500;
  localparam int USER  = 3000;
  localparam int TMO   = 2000;
  localparam int IDLEB = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, partial_req = 1'b0, done_chk_en = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_valid = 1'b0, s_last = 1'b0, cdone = 1'b0;
  logic s_ready, sclk, mosi, cs_n, cfg_rst_n, busy, done, error, timeout, operating;

  always #5 clk = ~clk;

  spi_cfg_seq #(
    .CLK_DIV(DIV), .RST_CYCLES(RSTC), .SETUP_CYCLES(SETUP),
    .USER_CYCLES(USER), .TIMEOUT_CYCLES(TMO), .IDLE_BYTES(IDLEB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .partial_req(partial_req),
    .done_chk_en(done_chk_en), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .cfg_rst_n(cfg_rst_n),
    .cdone(cdone), .busy(busy), .done(done), .error(error), .timeout(timeout),
    .operating(operating)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit exp_bits[$];
  int pin_toggles = 0;
  int t_cs_rise = 0, t_busy_fall = 0, t_done_rise = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  // Reference model of the pin protocol, evaluated every clock
  logic p_sclk = 1'b1, p_cs = 1'b1, p_rst = 1'b1, p_busy = 1'b0, p_done = 1'b0;
  int   low_cnt = 0, gap_cnt = 0;
  bit   first_fall = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      // R1: clock parked high with chip select released
      if (cs_n) chk(sclk == 1'b1, "R1 sclk idle", sclk, 1);
      // R11: operating only when idle
      if (busy) chk(operating == 1'b0, "R11 operating while busy", operating, 0);
      // R6: no acceptance while the wire is busy (sclk low means a bit is on)
      if (!sclk) chk(s_ready == 1'b0, "R6 ready while shifting", s_ready, 0);
      // R1: sample on rising sclk, MSB-first expectations queued by the driver
      if (!p_sclk && sclk && !cs_n) begin
        if (exp_bits.size() == 0) chk(0, "R5 extra sclk pulse", 1, 0);
        else begin
          bit e;
          e = exp_bits.pop_front();
          chk(mosi == e, "R1 mosi bit", mosi, e);
        end
      end
      // R2: reset falls only with chip select already low for a cycle
      if (p_rst && !cfg_rst_n) chk(p_cs == 1'b0, "R2 cs before reset", p_cs, 0);
      if (!cfg_rst_n) low_cnt++;
      if (!p_rst && cfg_rst_n) begin
        chk(low_cnt == RSTC, "R3 reset width", low_cnt, RSTC);
        low_cnt = 0; gap_cnt = 0; first_fall = 1;
      end else if (cfg_rst_n) gap_cnt++;
      if (p_sclk && !sclk && first_fall) begin
        chk(gap_cnt >= SETUP, "R4 setup gap", gap_cnt, SETUP);
        first_fall = 0;
      end
      if (p_cs && !cs_n) pin_toggles++;
      if (p_rst != cfg_rst_n) pin_toggles++;
      if (!p_cs && cs_n) begin
        t_cs_rise = cyc;
        chk(exp_bits.size() == 0, "R5 bits left at cs release", exp_bits.size(), 0);
      end
      if (p_busy && !busy) t_busy_fall = cyc;
      if (!p_done && done) t_done_rise = cyc;
    end
    p_sclk = sclk; p_cs = cs_n; p_rst = cfg_rst_n; p_busy = busy; p_done = done;
  end

  task automatic push_byte(input logic [7:0] b, input bit last);
    s_data = b; s_last = last; s_valid = 1'b1;
    while (1) begin
      if (s_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic pulse_start(input bit partial, input bit chk_en);
    partial_req = partial; done_chk_en = chk_en; start = 1'b1;
    @(negedge clk);
    start = 1'b0; partial_req = 1'b0;
  endtask

  // Runs one load; cdone_after < 0 leaves cdone low. gap_after >= 0 inserts an
  // underflow after that byte index.
  task automatic run_load(input logic [7:0] bytes[$], input bit chk_en,
                          input int cdone_after, input int gap_after);
    for (int i = 0; i < bytes.size(); i++)
      for (int k = 7; k >= 0; k--) exp_bits.push_back(bytes[i][k]);
    for (int i = 0; i < IDLEB * 8; i++) exp_bits.push_back(1'b0);
    pulse_start(1'b0, chk_en);
    chk(error == 0, "R10 error cleared by full start", error, 0);
    for (int i = 0; i < bytes.size(); i++) begin
      push_byte(bytes[i], i == bytes.size() - 1);
      if (i == gap_after) begin
        repeat (40) @(negedge clk);
        // R6: underflow keeps cs low and clock high, waiting for data
        chk(cs_n == 0, "R6 cs held in underflow", cs_n, 0);
        chk(sclk == 1, "R6 sclk parked in underflow", sclk, 1);
        chk(s_ready == 1, "R6 ready in underflow", s_ready, 1);
      end
    end
    while (!cs_n) @(negedge clk);
    if (cdone_after >= 0) begin
      repeat (cdone_after) @(negedge clk);
      cdone = 1'b1;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int t_cd;
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    // Reset state
    chk(cs_n == 1 && sclk == 1 && cfg_rst_n == 1, "R3 idle pins after reset", {cs_n, sclk, cfg_rst_n}, 7);
    chk(busy == 0 && s_ready == 0, "R6 idle handshake after reset", {busy, s_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: partial request refused with no pin activity
    begin
      int tg;
      tg = pin_toggles;
      pulse_start(1'b1, 1'b1);
      repeat (10) @(negedge clk);
      chk(error == 1, "R10 error on partial", error, 1);
      chk(busy == 0, "R10 busy stays low", busy, 0);
      chk(pin_toggles == tg, "R10 pins untouched", pin_toggles, tg);
    end

    // R8: normal load with done polling
    q = '{8'hA5, 8'h3C, 8'hFF, 8'h00};
    cdone = 1'b0;
    fork
      begin
        while (!cs_n || busy == 0) @(negedge clk);
        while (!cs_n) @(negedge clk);
        repeat (20) @(negedge clk);
        t_cd = cyc;
      end
    join_none
    run_load(q, 1'b1, 20, -1);
    chk(done == 1 && error == 0 && timeout == 0, "R8 completion flags", {done, error, timeout}, 4);
    chk(t_done_rise - t_cd >= USER, "R8 user wait min", t_done_rise - t_cd, USER);
    chk(t_done_rise - t_cd <= USER + 4, "R8 user wait max", t_done_rise - t_cd, USER + 4);
    // R11: operating follows cdone when idle
    chk(operating == 1, "R11 operating high", operating, 1);
    cdone = 1'b0;
    repeat (4) @(negedge clk);
    chk(operating == 0, "R11 operating low", operating, 0);

    // R6: underflow in mid-stream
    q = '{8'h81, 8'h7E, 8'hC3};
    run_load(q, 1'b1, 5, 0);
    chk(done == 1 && error == 0, "R6 load after underflow completes", {done, error}, 2);
    chk(exp_bits.size() == 0, "R5 all bits consumed", exp_bits.size(), 0);
    cdone = 1'b0;
    repeat (4) @(negedge clk);

    // R7: timeout with cdone stuck low
    q = '{8'h5A};
    run_load(q, 1'b1, -1, -1);
    chk(timeout == 1 && error == 1 && done == 0, "R7 timeout flags", {timeout, error, done}, 6);
    chk(t_busy_fall - t_cs_rise == TMO, "R7 timeout window", t_busy_fall - t_cs_rise, TMO);

    // R9: done check disabled, cdone ignored
    q = '{8'hF0, 8'h0F};
    run_load(q, 1'b0, -1, -1);
    chk(done == 1 && error == 0 && timeout == 0, "R9 flags without check", {done, error, timeout}, 4);
    chk(t_busy_fall - t_cs_rise == USER, "R9 user wait", t_busy_fall - t_cs_rise, USER);
    chk(cfg_rst_n == 1, "R3 reset released at end", cfg_rst_n, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule